// File: doc/BRIEF.md
# Ripple Add/Subtract/Increment/Decrement Unit

A purely combinational arithmetic unit that works on unsigned W-bit operands. Every function runs through an explicit chain of single-bit cells (full adders, half adders and a reduced full adder with one input tied high), and each cell uses only AND, OR and XOR gates. The carry or borrow travels from bit 0 towards the top bit.

A 2-bit function select picks what the unit computes:

- 0: add or subtract, as chosen by `mode`. Both use one shared chain, with one XOR per bit on `b`.
- 1: increment.
- 2: decrement.
- 3: pass `a` through unchanged.

`cin` controls the increment and the decrement with opposite polarity. A high `cin` makes the increment add one. A low `cin` makes the decrement subtract one. On the subtracting paths, `cout` is high when no borrow occurs.

Top module: `ripple_arith_unit`

## Requirements
- R1: With fsel = 0 and mode = 0, d equals (a + b) mod 2^W and cout equals the carry out of bit W-1. All inputs at zero give d = 0 and cout = 0.
- R2: With fsel = 0 and mode = 1, d equals (a - b) mod 2^W and cout is 1 exactly when a >= b.
- R3: With fsel = 0, cin has no effect on d or cout.
- R4: With fsel = 1, {cout, d} equals a + cin, so the value grows by one only when cin is 1.
- R5: With fsel = 2 and cin = 0, d equals (a - 1) mod 2^W, and cout is 0 only when a = 0.
- R6: With fsel = 2 and cin = 1, d equals a and cout is 1.
- R7: With fsel = 3, d equals a and cout is 0, whatever b, mode and cin are.
- R8: With fsel = 1 or fsel = 2, neither b nor mode has any effect on d or cout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | First operand |
| b | input | W | Second operand (add/subtract only) |
| cin | input | 1 | Condition for increment (high) and decrement (low) |
| fsel | input | 2 | Function: 0 add/sub, 1 increment, 2 decrement, 3 pass |
| mode | input | 1 | For fsel 0: 0 adds, 1 subtracts |
| d | output | W | Result |
| cout | output | 1 | Final carry; on subtract and decrement, high means no borrow |

## Verification
The unit holds no state. A wrong cell or a misrouted carry therefore shows up as a bad `d` or `cout` as soon as the inputs settle, for any operand pair whose carry passes through the faulty stage. The bench sweeps every operand pair, every `cin`, every function and every `mode` at a width of 4. Each carry and borrow path is therefore driven through every stage, including the full wrap cases: all ones plus one, zero minus one, and subtracting from a smaller value. The bench also reaches the cases where `cin`, `b` or `mode` must be ignored.

// File: rtl/ripple_arith_unit.sv
module rau_full_add (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  logic p;
  assign p  = x ^ y;
  assign s  = p ^ ci;
  assign co = (x & y) | (p & ci);
endmodule

module rau_half_add (
  input  logic x,
  input  logic y,
  output logic s,
  output logic co
);
  assign s  = x ^ y;
  assign co = x & y;
endmodule

module rau_ones_add (
  input  logic x,
  input  logic ci,
  output logic s,
  output logic co
);
  assign s  = x ^ ci ^ 1'b1;
  assign co = x | ci;
endmodule

module ripple_arith_unit #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic [1:0]   fsel,
  input  logic         mode,
  output logic [W-1:0] d,
  output logic         cout
);
  logic [W-1:0] b_x, s_as, s_inc, s_dec;
  logic [W:0]   c_as, c_inc, c_dec;

  assign b_x      = b ^ {W{mode}};
  assign c_as[0]  = mode;
  assign c_inc[0] = cin;
  assign c_dec[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    rau_full_add u_as  (.x(a[i]), .y(b_x[i]), .ci(c_as[i]), .s(s_as[i]),  .co(c_as[i+1]));
    rau_half_add u_inc (.x(a[i]), .y(c_inc[i]),            .s(s_inc[i]), .co(c_inc[i+1]));
    rau_ones_add u_dec (.x(a[i]), .ci(c_dec[i]),           .s(s_dec[i]), .co(c_dec[i+1]));
  end

  always_comb begin
    case (fsel)
      2'd0:    begin d = s_as;  cout = c_as[W];  end
      2'd1:    begin d = s_inc; cout = c_inc[W]; end
      2'd2:    begin d = s_dec; cout = c_dec[W]; end
      default: begin d = a;     cout = 1'b0;     end
    endcase
  end
endmodule

module ripple_arith_unit_chk #(
  parameter int W = 8
) (
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic         cin,
  input logic [1:0]   fsel,
  input logic         mode,
  input logic [W-1:0] d,
  input logic         cout
);
  logic known;
  assign known = !$isunknown({a, b, cin, fsel, mode});

  always_comb begin
    if (known) begin
      if (fsel == 2'd0 && !mode)
        AST_ADD_SUM: assert ({cout, d} == ({1'b0, a} + {1'b0, b})); // R1
      if (fsel == 2'd0 && mode)
        AST_SUB_NOBORROW: assert (cout == (a >= b)); // R2
      if (fsel == 2'd1 && !cin)
        AST_INC_HOLD: assert (d == a && !cout); // R4
      if (fsel == 2'd2 && cin)
        AST_DEC_HOLD: assert (d == a && cout); // R6
      if (fsel == 2'd2 && !cin)
        AST_DEC_BORROW: assert (cout == (a != '0)); // R5
      if (fsel == 2'd3)
        AST_PASS_A: assert (d == a && !cout); // R7
    end
  end
endmodule

bind ripple_arith_unit ripple_arith_unit_chk #(.W(W)) u_chk (.*);

// File: tb/test_ripple_arith_unit.sv
module test_ripple_arith_unit;
  localparam int W = 4;
  localparam int M = 1 << W;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [W-1:0] a, b, d;
  logic cin, mode, cout;
  logic [1:0] fsel;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  ripple_arith_unit #(.W(W)) i_ripple_arith_unit (
    .a(a), .b(b), .cin(cin), .fsel(fsel), .mode(mode), .d(d), .cout(cout)
  );

  task automatic check(input string req, input logic [W-1:0] ed, input logic ec);
    n_chk++;
    if (d !== ed || cout !== ec) begin
      n_bad++;
      $display("FAIL %s a=%0d b=%0d cin=%0b fsel=%0d mode=%0b: got d=%0d cout=%0b, want d=%0d cout=%0b",
               req, a, b, cin, fsel, mode, d, cout, ed, ec);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!done && cyc > 150000) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: got cycle %0d, want end before 150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; cin = 0; mode = 0; fsel = 2'd0;
    @(negedge clk);
    check("R1 zero inputs", '0, 1'b0);
    for (int fs = 0; fs < 4; fs++)
      for (int md = 0; md < 2; md++)
        for (int ci = 0; ci < 2; ci++)
          for (int av = 0; av < M; av++)
            for (int bv = 0; bv < M; bv++) begin
              int e;
              logic ec;
              string req;
              a = av[W-1:0]; b = bv[W-1:0]; cin = ci[0]; mode = md[0]; fsel = fs[1:0];
              @(negedge clk);
              case (fs)
                0: if (md == 0) begin
                     e = av + bv; ec = (e >= M); req = "R1/R3 add";
                   end else begin
                     e = av - bv; ec = (av >= bv); req = "R2/R3 sub";
                   end
                1: begin e = av + ci; ec = (e >= M); req = "R4/R8 inc"; end
                2: if (ci == 1) begin
                     e = av; ec = 1'b1; req = "R6/R8 dec hold";
                   end else begin
                     e = av - 1; ec = (av != 0); req = "R5/R8 dec";
                   end
                default: begin e = av; ec = 1'b0; req = "R7 pass"; end
              endcase
              check(req, e[W-1:0], ec);
            end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule